// File: doc/BRIEF.md
# Dual-Command Watchdog Timer

This block is a watchdog counter with status flags. Software must service it, or it resets the system when its period runs out. One service takes two different clear commands, issued in either order, one after the other. Repeating a command changes nothing. The block keeps two flags that tell software why the last reset or wake-up happened. One flag records an expired watchdog (`to_flag`). The other records entry into power-down (`pd_flag`). A halt command puts the block into power-down. Only a watchdog expiry or a power-on reset brings it out again.

The watchdog can count on either of two sources. The first is pulses from a dedicated oscillator, delivered as single-cycle `osc_tick` strobes in the `clk` domain. The second is the instruction clock, which is `clk` divided by four. The instruction clock stops in power-down, so with that source the watchdog cannot wake the part. A 3-bit select sets the period to 2^(8+n) watchdog ticks. While the global enable is low, the count is held and the flags are kept.

Top module: `dual_clear_watchdog`

## Requirements
- R1: After power-on reset (`rst_n` low), `wdt_rst`, `wake`, `halted`, `to_flag` and `pd_flag` are all 0, the count is 0 and no clear command is recorded.
- R2: A clear command that differs from the one recorded before it completes a service. A lone `clr_a` cycle followed later by a lone `clr_b` cycle completes one, and so does `clr_b` followed by `clr_a`. A completed service sets the count to 0 in that cycle, clears `to_flag` and `pd_flag`, and empties the record.
- R3: A clear command equal to the recorded one has no effect. The count, the flags and the record are unchanged.
- R4: After a completed service the record is empty, so a single further command only gets recorded and does not clear the count.
- R5: The watchdog expires on the 2^(8+`psel`)-th counted tick after the count was last zeroed. In normal operation, expiry drives `wdt_rst` high for exactly one cycle, sets `to_flag` to 1, sets `pd_flag` to 0 and zeroes the count.
- R6: With `src_sel`=0 the watchdog counts one tick per cycle in which `osc_tick` is 1. With `src_sel`=1 it counts one tick every 4 `clk` cycles while not halted. The first of these ticks comes on the 4th edge after reset.
- R7: A lone `halt_cmd` while running sets `halted` to 1, sets `pd_flag` to 1, clears `to_flag`, zeroes the count and the clock divider, and empties the record. The edge that takes the halt counts no tick.
- R8: While halted with `src_sel`=1 the watchdog does not count, so `wake` never rises and `halted` stays 1.
- R9: Expiry while halted drives `wake` high for one cycle instead of `wdt_rst`, clears `halted`, sets `to_flag` to 1 and leaves `pd_flag` at 1.
- R10: While `wdt_en` is 0 the count holds, no expiry occurs and the flags keep their values. Counting resumes from the held value.
- R11: Clear commands are ignored while halted. A cycle with `clr_a` and `clr_b` both high is also ignored and does not update the record.
- R12: Expiry takes priority over a clear or a halt in the same cycle. The expiry occurs, the flags are set as in R5, and the record is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (always running; power-down is modelled by state) |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| osc_tick | input | 1 | Single-cycle strobe from the dedicated oscillator |
| src_sel | input | 1 | Watchdog source: 0 dedicated oscillator, 1 instruction clock |
| psel | input | 3 | Period select, expiry after 2^(8+psel) ticks |
| wdt_en | input | 1 | Global enable; low holds the count |
| clr_a | input | 1 | First clear command |
| clr_b | input | 1 | Second clear command |
| halt_cmd | input | 1 | Enter power-down |
| wdt_rst | output | 1 | One-cycle reset request on expiry in normal operation |
| wake | output | 1 | One-cycle wake-up on expiry in power-down |
| halted | output | 1 | Power-down state |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
Each scenario measures the number of edges from a known zero point to the expiry pulse. A clear that was wrongly taken or wrongly missed then shows up as an exact shift in that number. The cases are:

- A repeated command, which a design that only looks for any clear would accept.
- A single command after a completed pair, which a design that keeps the record would accept.
- Both commands in the same cycle, which a design that does not qualify the commands would take as a pair.
- A pair completing on the expiry edge, which a design with the wrong priority would turn into a silent clear.
- Commands issued during power-down, which would wrongly clear the power-down flag.

Power-down is tested with both sources. With the dedicated oscillator the block must wake with both flags set. With the instruction clock it must stay asleep, and a design that forgets this would wake it.

// File: rtl/dual_clear_watchdog.sv
module dual_clear_watchdog #(
  parameter int BASE_LOG = 8,
  parameter int SEL_W    = 3,
  parameter int DIV_LOG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             src_sel,
  input  logic [SEL_W-1:0] psel,
  input  logic             wdt_en,
  input  logic             clr_a,
  input  logic             clr_b,
  input  logic             halt_cmd,
  output logic             wdt_rst,
  output logic             wake,
  output logic             halted,
  output logic             to_flag,
  output logic             pd_flag
);
  localparam int CNT_W = BASE_LOG + (1 << SEL_W) - 1;

  typedef enum logic [1:0] {LAST_NONE, LAST_A, LAST_B} last_t;

  logic [DIV_LOG-1:0] div_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   top_val;
  last_t              last_q;

  wire inst_tick = !halted && (&div_q);
  wire wd_tick   = src_sel ? inst_tick : osc_tick;
  wire step      = wd_tick && wdt_en;

  assign top_val = (CNT_W'(1) << (BASE_LOG + 32'(psel))) - CNT_W'(1);

  wire expire    = step && (cnt_q == top_val);
  wire a_only    = clr_a && !clr_b && !halted;
  wire b_only    = clr_b && !clr_a && !halted;
  wire pair_done = (a_only && last_q == LAST_B) || (b_only && last_q == LAST_A);
  wire do_halt   = halt_cmd && !halted && !expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      div_q <= '0;
    else if (halted || do_halt)
      div_q <= '0;
    else
      div_q <= div_q + DIV_LOG'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      last_q  <= LAST_NONE;
      wdt_rst <= 1'b0;
      wake    <= 1'b0;
      halted  <= 1'b0;
      to_flag <= 1'b0;
      pd_flag <= 1'b0;
    end else begin
      wdt_rst <= 1'b0;
      wake    <= 1'b0;
      if (expire) begin
        cnt_q   <= '0;
        last_q  <= LAST_NONE;
        to_flag <= 1'b1;
        if (halted) begin
          wake   <= 1'b1;
          halted <= 1'b0;
        end else begin
          wdt_rst <= 1'b1;
          pd_flag <= 1'b0;
        end
      end else if (do_halt) begin
        cnt_q   <= '0;
        last_q  <= LAST_NONE;
        halted  <= 1'b1;
        pd_flag <= 1'b1;
        to_flag <= 1'b0;
      end else if (pair_done) begin
        cnt_q   <= '0;
        last_q  <= LAST_NONE;
        to_flag <= 1'b0;
        pd_flag <= 1'b0;
      end else begin
        if (step)
          cnt_q <= cnt_q + CNT_W'(1);
        if (a_only)
          last_q <= LAST_A;
        else if (b_only)
          last_q <= LAST_B;
      end
    end
  end
endmodule

// File: rtl/dual_clear_watchdog_checker.sv
module dual_clear_watchdog_checker (
  input logic clk,
  input logic rst_n,
  input logic src_sel,
  input logic wdt_en,
  input logic wdt_rst,
  input logic wake,
  input logic halted,
  input logic to_flag,
  input logic pd_flag
);
  a_r5_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  a_r5_rst_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (to_flag && !pd_flag && !halted && !wake));

  a_r9_wake_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (!halted && to_flag && pd_flag && $past(halted)));

  a_r9_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  a_r7_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (pd_flag && !to_flag));

  a_r8_no_inst_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halted) && $past(src_sel)) |-> !wake);

  a_r10_hold_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wdt_en) |-> (!wdt_rst && !wake));

  a_r10_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wdt_en) && !halted && $past(!halted)) |-> ($stable(to_flag) || !to_flag));
endmodule

bind dual_clear_watchdog dual_clear_watchdog_checker u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .src_sel (src_sel),
  .wdt_en  (wdt_en),
  .wdt_rst (wdt_rst),
  .wake    (wake),
  .halted  (halted),
  .to_flag (to_flag),
  .pd_flag (pd_flag)
);

// File: tb/dual_clear_watchdog_bench.sv
`timescale 1ns/1ps
module dual_clear_watchdog_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, src_sel = 1'b0, wdt_en = 1'b1;
  logic clr_a = 1'b0, clr_b = 1'b0, halt_cmd = 1'b0;
  logic [2:0] psel = 3'd0;
  logic wdt_rst, wake, halted, to_flag, pd_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_clear_watchdog u_dual_clear_watchdog (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .src_sel(src_sel), .psel(psel),
    .wdt_en(wdt_en), .clr_a(clr_a), .clr_b(clr_b), .halt_cmd(halt_cmd),
    .wdt_rst(wdt_rst), .wake(wake), .halted(halted), .to_flag(to_flag), .pd_flag(pd_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic sel, input logic [2:0] ps, input logic tick);
    rst_n = 1'b0; clr_a = 0; clr_b = 0; halt_cmd = 0; wdt_en = 1;
    src_sel = sel; psel = ps; osc_tick = tick;
    repeat (3) cyc();
    rst_n = 1'b1;
  endtask

  // Edges numbered from 1 after the call; returns the edge of the first pulse
  // and which pulse (1 wdt_rst, 2 wake, 0 none within maxn).
  task automatic pulse_run(input int ka, input int ka2, input int kb, input int kb2,
                           input int kab, input int khalt, input int off_lo, input int off_hi,
                           input int maxn, output int n, output int which);
    n = 0; which = 0;
    for (int e = 1; e <= maxn; e++) begin
      clr_a    = (e == ka) || (e == ka2) || (e == kab);
      clr_b    = (e == kb) || (e == kb2) || (e == kab);
      halt_cmd = (e == khalt);
      wdt_en   = !(e >= off_lo && e <= off_hi);
      cyc();
      if (wdt_rst || wake) begin
        n = e; which = wdt_rst ? 1 : 2;
        break;
      end
    end
    clr_a = 0; clr_b = 0; halt_cmd = 0; wdt_en = 1;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 3'd0, 1'b0);
    cyc();
    chk("R1 wdt_rst", wdt_rst, 0); chk("R1 wake", wake, 0); chk("R1 halted", halted, 0);
    chk("R1 to_flag", to_flag, 0); chk("R1 pd_flag", pd_flag, 0);
  endtask

  task automatic t_period();
    int n, w;
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(0, 0, 0, 0, 0, 0, 1, 0, 70000, n, w);
    chk("R5 period psel0", n, 256); chk("R5 kind", w, 1);
    chk("R5 to_flag", to_flag, 1); chk("R5 pd_flag", pd_flag, 0);
    cyc();
    chk("R5 one-cycle pulse", wdt_rst, 0);
    do_reset(1'b0, 3'd3, 1'b1);
    pulse_run(0, 0, 0, 0, 0, 0, 1, 0, 70000, n, w);
    chk("R5 period psel3", n, 2048);
    do_reset(1'b0, 3'd7, 1'b1);
    pulse_run(0, 0, 0, 0, 0, 0, 1, 0, 70000, n, w);
    chk("R5 period psel7", n, 32768);
  endtask

  task automatic t_pair();
    int n, w;
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(100, 0, 150, 0, 0, 0, 1, 0, 70000, n, w);
    chk("R2 A then B", n, 406);
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(120, 0, 100, 0, 0, 0, 1, 0, 70000, n, w);
    chk("R2 B then A", n, 376);
    osc_tick = 0;
    clr_a = 1; cyc(); clr_a = 0;
    chk("R2 single cmd keeps to_flag", to_flag, 1);
    clr_b = 1; cyc(); clr_b = 0;
    chk("R2 pair clears to_flag", to_flag, 0);
  endtask

  task automatic t_repeat();
    int n, w;
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(100, 120, 0, 0, 0, 0, 1, 0, 70000, n, w);
    chk("R3 repeated A ignored", n, 256);
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(50, 0, 60, 100, 0, 0, 1, 0, 70000, n, w);
    chk("R4 single after pair", n, 316);
  endtask

  task automatic t_enable();
    int n, w;
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(0, 0, 0, 0, 0, 0, 100, 149, 70000, n, w);
    chk("R10 hold shifts expiry", n, 306);
    wdt_en = 0;
    repeat (400) begin
      cyc();
      if (wdt_rst) chk("R10 no expiry while disabled", 1, 0);
    end
    chk("R10 to_flag kept", to_flag, 1);
    wdt_en = 1;
  endtask

  task automatic t_source();
    int n, w;
    do_reset(1'b1, 3'd0, 1'b0);
    pulse_run(0, 0, 0, 0, 0, 0, 1, 0, 70000, n, w);
    chk("R6 instruction clock period", n, 1024);
    do_reset(1'b0, 3'd0, 1'b0);
    pulse_run(0, 0, 0, 0, 0, 0, 1, 0, 2000, n, w);
    chk("R6 no osc ticks no expiry", w, 0);
  endtask

  task automatic t_halt();
    int n, w;
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(0, 0, 0, 0, 0, 0, 1, 0, 70000, n, w);
    halt_cmd = 1; cyc(); halt_cmd = 0;
    chk("R7 halted", halted, 1); chk("R7 pd_flag", pd_flag, 1); chk("R7 to_flag", to_flag, 0);
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(0, 0, 0, 0, 0, 201, 1, 0, 70000, n, w);
    chk("R7 halt zeroes count", n, 457);
    chk("R9 wake not reset", w, 2);
    chk("R9 halted cleared", halted, 0); chk("R9 to_flag", to_flag, 1); chk("R9 pd_flag", pd_flag, 1);
    cyc();
    chk("R9 one-cycle wake", wake, 0);
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(50, 0, 60, 0, 0, 1, 1, 0, 70000, n, w);
    chk("R11 clears ignored in halt", n, 257);
    chk("R11 pd_flag kept", pd_flag, 1);
    do_reset(1'b1, 3'd0, 1'b0);
    pulse_run(0, 0, 0, 0, 0, 1, 1, 0, 3000, n, w);
    chk("R8 no wake on instruction clock", w, 0);
    chk("R8 still halted", halted, 1);
  endtask

  task automatic t_priority();
    int n, w;
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(0, 0, 150, 0, 100, 0, 1, 0, 70000, n, w);
    chk("R11 simultaneous ignored", n, 256);
    do_reset(1'b0, 3'd0, 1'b1);
    pulse_run(200, 0, 256, 0, 0, 0, 1, 0, 70000, n, w);
    chk("R12 expiry beats clear", n, 256);
    chk("R12 to_flag", to_flag, 1);
  endtask

  initial begin
    t_reset();
    t_period();
    t_pair();
    t_repeat();
    t_enable();
    t_source();
    t_halt();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule